// File: doc/BRIEF.md
# Multi-rate clock and reset sequencer

The sequencer turns one fast tick clock into a six-bit control word that drives the clock and reset pins of a processor core model. Eight ticks form one base cycle. Within each base cycle the block walks a fixed pattern that yields a base-rate clock, a double-rate clock and a quadruple-rate clock, all phase aligned to the frame start. The pattern is the complement of the tick index. The same word carries an active-high core reset bit.

A base-cycle counter starts at 1 and advances at every frame boundary. The reset bit is released once that count passes a programmable threshold. A thread-halt mask, which starts with every thread halted, is released later once the count passes a second threshold. A one-cycle `done` pulse marks the moment the count passes a run limit, so a harness can end its run. A synchronous `restart` input returns the whole sequence to its start without the block-level reset.

Top module: `clkrst_seq`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the next state is `ctl_bundle` = 0x3C, `thread_stop` all ones, `base_cycle` = 1, `frame_tick` = 0 and `done` = 0.
- R2: `ctl_bundle` carries the base-rate clock in bit 5, the core reset in bit 4, the double-rate clock in bit 3 and the quadruple-rate clock in bit 2. Bits 1 and 0 are always 0.
- R3: At each edge with `frame_tick` = k, the clock field {bit5, bit3, bit2} becomes 7 - k. Tick 0 gives 111 and tick 7 gives 000.
- R4: `frame_tick` counts 0 to 7 and wraps. `base_cycle` increments at the edge where `frame_tick` wraps from 7 to 0, and it holds at its maximum value.
- R5: The reset bit clears at the first edge where `base_cycle` > `RST_CYCLES` (default 10). It is never set again until restart or reset.
- R6: `thread_stop` becomes all zeros at the first edge where `base_cycle` > `STOP_CYCLES` (default 200). It stays zero until restart or reset.
- R7: `done` is high for exactly one cycle. That cycle is the one in which `base_cycle` has just become `RUN_LIMIT` + 1 (default 1001).
- R8: When `restart` is high at an edge, it restores the R1 state at that edge. It takes priority over every other update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous restart of the sequence |
| ctl_bundle | output | 6 | Packed clocks and core reset |
| thread_stop | output | THREADS (2) | Thread-halt mask, 1 = halted |
| frame_tick | output | 3 | Tick index within the base cycle |
| base_cycle | output | CYC_W (16) | Base-cycle count, starts at 1 |
| done | output | 1 | One-cycle pulse past the run limit |

## Verification
The checker tests the following on every cycle:
- the clock field follows the complement of the previous tick index;
- the tick and base-cycle counters step correctly;
- the reset bit and the halt mask, once cleared, stay cleared;
- `done` appears only at the run-limit boundary;
- a restart leaves the start state behind.

Stickiness alone does not prove that the releases happen at the right base cycle. Only the bench's long runs show that the reset drops after the tenth cycle, the halt mask after the two-hundredth and `done` after the thousandth. The same runs check the effect of a restart landing on or near those boundaries.

// File: rtl/clkrst_pkg.sv
// Package: shared constants and types for the clock/reset sequencer.
// Assumes a fixed eight-tick frame; bit positions are what the core decodes.
package clkrst_pkg;

    localparam int FRAME_LEN  = 8;
    localparam int TICK_W     = $clog2(FRAME_LEN);
    localparam int BUNDLE_W   = 6;
    localparam int BIT_CLK1X  = 5;
    localparam int BIT_CRST   = 4;
    localparam int BIT_CLK2X  = 3;
    localparam int BIT_CLK4X  = 2;
    localparam logic [BUNDLE_W-1:0] BUNDLE_INIT = 6'h3C;

    typedef struct packed {
        logic c1x;
        logic c2x;
        logic c4x;
    } clk_pat_t;

    // Clock phases for a tick index: the complement of the index.
    function automatic clk_pat_t pattern_at(input logic [TICK_W-1:0] idx);
        logic [TICK_W-1:0] inv;
        inv = ~idx;
        return clk_pat_t'(inv);
    endfunction

endpackage

// File: rtl/frame_counter.sv
// Module: frame_counter
// Counts ticks within the eight-tick frame and counts base cycles.
// The base-cycle count starts at 1 and saturates at all ones.
// Assumes synchronous active-low reset; restart has the same effect.
module frame_counter
    import clkrst_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    output logic [TICK_W-1:0] tick_o,
    output logic [CYC_W-1:0]  cycle_o,
    output logic              wrap_o
);

    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(FRAME_LEN - 1);
    localparam logic [CYC_W-1:0]  CYC_MAX   = '1;

    logic [TICK_W-1:0] tick_q;
    logic [CYC_W-1:0]  cycle_q;

    // Frame boundary: the last tick of the current frame.
    assign wrap_o = (tick_q == TICK_LAST);

    // Advance the tick index; bump the base-cycle count at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tick_q  <= '0;
            cycle_q <= CYC_W'(1);
        end else begin
            tick_q <= tick_q + 1'b1;
            if (wrap_o && (cycle_q != CYC_MAX)) begin
                cycle_q <= cycle_q + 1'b1;
            end
        end
    end

    assign tick_o  = tick_q;
    assign cycle_o = cycle_q;

endmodule

// File: rtl/clk_pattern.sv
// Module: clk_pattern
// Registers the three clock phases from the pattern for the current tick.
// All phases start high after reset or restart.
module clk_pattern
    import clkrst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [TICK_W-1:0] tick_i,
    output clk_pat_t          pat_o
);

    clk_pat_t pat_q;

    // Load the pattern entry for this tick on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pat_q <= '1;
        end else begin
            pat_q <= pattern_at(tick_i);
        end
    end

    assign pat_o = pat_q;

endmodule

// File: rtl/seq_timers.sv
// Module: seq_timers
// Releases the core reset and then the thread-halt mask at programmed
// base-cycle thresholds, and pulses done past the run limit.
// Both releases are sticky until reset or restart.
module seq_timers #(
    parameter int          CYC_W       = 16,
    parameter int          THREADS     = 2,
    parameter int unsigned RST_CYCLES  = 10,
    parameter int unsigned STOP_CYCLES = 200,
    parameter int unsigned RUN_LIMIT   = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [CYC_W-1:0]   cycle_i,
    input  logic               wrap_i,
    output logic               core_rst_o,
    output logic [THREADS-1:0] stop_o,
    output logic               done_o
);

    localparam logic [CYC_W-1:0] RST_LIM  = CYC_W'(RST_CYCLES);
    localparam logic [CYC_W-1:0] STOP_LIM = CYC_W'(STOP_CYCLES);
    localparam logic [CYC_W-1:0] RUN_LIM  = CYC_W'(RUN_LIMIT);

    logic               rst_q;
    logic [THREADS-1:0] stop_q;
    logic               done_q;

    // Sticky release of the core reset and of the thread-halt mask.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            rst_q  <= 1'b1;
            stop_q <= '1;
        end else begin
            if (cycle_i > RST_LIM) begin
                rst_q <= 1'b0;
            end
            if (cycle_i > STOP_LIM) begin
                stop_q <= '0;
            end
        end
    end

    // One-cycle pulse at the wrap that moves the count past the run limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            done_q <= 1'b0;
        end else begin
            done_q <= wrap_i && (cycle_i == RUN_LIM);
        end
    end

    assign core_rst_o = rst_q;
    assign stop_o     = stop_q;
    assign done_o     = done_q;

endmodule

// File: rtl/clkrst_seq.sv
// Module: clkrst_seq (top)
// Packs the multi-rate clock phases and the core reset into the control
// word, and exposes the thread-halt mask, counters and done pulse.
// Assumes clk is the fast tick; synchronous active-low reset.
module clkrst_seq
    import clkrst_pkg::*;
#(
    parameter int          CYC_W       = 16,
    parameter int          THREADS     = 2,
    parameter int unsigned RST_CYCLES  = 10,
    parameter int unsigned STOP_CYCLES = 200,
    parameter int unsigned RUN_LIMIT   = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    output logic [5:0]         ctl_bundle,
    output logic [THREADS-1:0] thread_stop,
    output logic [2:0]         frame_tick,
    output logic [CYC_W-1:0]   base_cycle,
    output logic               done
);

    logic [TICK_W-1:0] tick_w;
    logic [CYC_W-1:0]  cycle_w;
    logic              wrap_w;
    clk_pat_t          pat_w;
    logic              core_rst_w;

    frame_counter #(.CYC_W(CYC_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick_o  (tick_w),
        .cycle_o (cycle_w),
        .wrap_o  (wrap_w)
    );

    clk_pattern u_pat (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick_i  (tick_w),
        .pat_o   (pat_w)
    );

    seq_timers #(
        .CYC_W       (CYC_W),
        .THREADS     (THREADS),
        .RST_CYCLES  (RST_CYCLES),
        .STOP_CYCLES (STOP_CYCLES),
        .RUN_LIMIT   (RUN_LIMIT)
    ) u_timers (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .cycle_i    (cycle_w),
        .wrap_i     (wrap_w),
        .core_rst_o (core_rst_w),
        .stop_o     (thread_stop),
        .done_o     (done)
    );

    // Place each clock phase and the reset at its decoded bit position.
    always_comb begin
        ctl_bundle            = '0;
        ctl_bundle[BIT_CLK1X] = pat_w.c1x;
        ctl_bundle[BIT_CRST]  = core_rst_w;
        ctl_bundle[BIT_CLK2X] = pat_w.c2x;
        ctl_bundle[BIT_CLK4X] = pat_w.c4x;
    end

    assign frame_tick = tick_w;
    assign base_cycle = cycle_w;

endmodule

// File: rtl/clkrst_seq_chk.sv
// Module: clkrst_seq_chk
// Assertion checker bound to clkrst_seq; observes its ports only.
module clkrst_seq_chk #(
    parameter int          CYC_W     = 16,
    parameter int          THREADS   = 2,
    parameter int unsigned RUN_LIMIT = 1000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               restart,
    input logic [5:0]         ctl_bundle,
    input logic [THREADS-1:0] thread_stop,
    input logic [2:0]         frame_tick,
    input logic [CYC_W-1:0]   base_cycle,
    input logic               done
);

    // R3
    clk_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> {ctl_bundle[5], ctl_bundle[3], ctl_bundle[2]} == ~$past(frame_tick));

    // R4
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> frame_tick == 3'($past(frame_tick) + 3'd1));

    // R4
    cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && frame_tick == 3'd7 && base_cycle != '1)
        |=> base_cycle == CYC_W'($past(base_cycle) + 1'b1));

    // R5
    reset_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !ctl_bundle[4]) |=> !ctl_bundle[4]);

    // R6
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && thread_stop == '0) |=> thread_stop == '0);

    // R7
    done_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (base_cycle == CYC_W'(RUN_LIMIT + 1) && frame_tick == 3'd0));

    // R8
    restart_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ctl_bundle == 6'h3C && thread_stop == '1
                     && base_cycle == CYC_W'(1) && frame_tick == 3'd0 && !done));

endmodule

bind clkrst_seq clkrst_seq_chk #(
    .CYC_W     (CYC_W),
    .THREADS   (THREADS),
    .RUN_LIMIT (RUN_LIMIT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .ctl_bundle  (ctl_bundle),
    .thread_stop (thread_stop),
    .frame_tick  (frame_tick),
    .base_cycle  (base_cycle),
    .done        (done)
);

// File: tb/clkrst_seq_tb_top.sv
`timescale 1ns/1ps
// Bench for clkrst_seq: random restarts plus directed boundary runs,
// compared against closed-form expectations from the tick count.
module clkrst_seq_tb_top;

    localparam int RST_C  = 10;
    localparam int STOP_C = 200;
    localparam int RUN_C  = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic [5:0]  ctl_bundle;
    logic [1:0]  thread_stop;
    logic [2:0]  frame_tick;
    logic [15:0] base_cycle;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;
    int t     = 0;   // ticks since last reset/restart
    int done_seen = 0;

    always #10 clk = ~clk;  // 50 MHz

    clkrst_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .ctl_bundle  (ctl_bundle),
        .thread_stop (thread_stop),
        .frame_tick  (frame_tick),
        .base_cycle  (base_cycle),
        .done        (done)
    );

    function automatic int exp_clk(input int tt);
        return (tt == 0) ? 7 : 7 - ((tt - 1) % 8);
    endfunction
    function automatic int exp_rst(input int tt);
        return (tt <= 8 * RST_C) ? 1 : 0;
    endfunction
    function automatic int exp_stop(input int tt);
        return (tt <= 8 * STOP_C) ? 3 : 0;
    endfunction
    function automatic int exp_done(input int tt);
        return (tt == 8 * RUN_C) ? 1 : 0;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0d)", req, what, act, exp, t);
        end
    endtask

    task automatic check_all();
        check("R3", "clock field", {ctl_bundle[5], ctl_bundle[3], ctl_bundle[2]}, exp_clk(t));
        check("R5", "reset bit", ctl_bundle[4], exp_rst(t));
        check("R2", "low bits", ctl_bundle[1:0], 0);
        check("R6", "thread stop", thread_stop, exp_stop(t));
        check("R4", "tick", frame_tick, t % 8);
        check("R4", "base cycle", base_cycle, 1 + t / 8);
        check("R7", "done", done, exp_done(t));
        if (done) done_seen++;
    endtask

    // One tick: drive inputs at negedge, let the edge pass, check at negedge.
    task automatic step(input logic rn, input logic rs);
        rst_n   = rn;
        restart = rs;
        @(posedge clk);
        if (!rn || rs) t = 0; else t++;
        @(negedge clk);
        check_all();
    endtask

    task automatic run_to(input int target);
        while (t < target) step(1'b1, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        // R1: reset state
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check("R1", "bundle after reset", ctl_bundle, 8'h3C);
        check("R1", "stop after reset", thread_stop, 3);

        // Random restarts early in the sequence (R8)
        for (int i = 0; i < 3000; i++) begin
            logic rs;
            rs = (($urandom % 40) == 0);
            step(1'b1, rs);
            if (rs) check("R8", "bundle after restart", ctl_bundle, 8'h3C);
        end

        // Directed: restart on the edge where reset would release (R8, R5)
        step(1'b1, 1'b1);
        run_to(8 * RST_C);
        step(1'b1, 1'b1);
        check("R8", "reset bit held by restart", ctl_bundle[4], 1);
        run_to(8 * RST_C + 1);
        check("R5", "reset released", ctl_bundle[4], 0);

        // Directed: restart just after stop release (R8, R6)
        run_to(8 * STOP_C + 2);
        check("R6", "stop released", thread_stop, 0);
        step(1'b1, 1'b1);
        check("R8", "stop restored", thread_stop, 3);

        // Reset mid-run returns to start (R1)
        run_to(500);
        step(1'b0, 1'b0);
        check("R1", "cycle after reset", base_cycle, 1);

        // Long run through the done pulse (R7)
        done_seen = 0;
        run_to(8 * RUN_C + 24);
        check("R7", "done pulse count", done_seen, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20ns * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule